// File: doc/BRIEF.md
# Signal Notification Register Pair

The block holds a small set of notification registers (two by default) for one accelerator core. Any number of writer ports, such as the host and peer cores, can deliver a bit pattern to any register in any cycle. The core collects a register through a blocking read channel. It raises a request, and the block acknowledges in the first cycle the register holds a non-zero value. The acknowledged value is handed over, and the register is cleared in that same cycle.

Each register runs in one of two modes. In overwrite mode a delivery replaces the contents. In accumulate mode a delivery is ORed into the contents, so that several producers can raise flags independently. Bits delivered in the cycle of a core read are never dropped: they land in the freshly cleared register and go to the next read.

A non-blocking count tells the core whether a register has anything pending. An optional event line per register follows the non-zero state. A host status port shows the contents without disturbing them.

Top module: `sig_notify`

## Requirements
- R1: After reset every register is zero and in overwrite mode (`mode_now` bit = 0), and every `evt_out` bit is low. A delivery to one register, chosen by a writer's `wr_sel` value equal to the register index, never changes another register.
- R2: In overwrite mode (mode bit 0) a delivery replaces the register with the delivered value from the next cycle on.
- R3: In accumulate mode (mode bit 1) a delivery is ORed into the register, which keeps every bit delivered since the last core read.
- R4: When `rd_req` is high and the register is non-zero, `rd_ack` is high in that cycle and `rd_data` carries the current value. The register becomes zero in the next cycle unless a delivery arrives in the same cycle.
- R5: A delivery in the same cycle as an acknowledged read is applied after the clear, so the register holds exactly that delivery in the next cycle.
- R6: While the register is zero, `rd_req` produces no `rd_ack` and leaves the register unchanged. The read completes in the first cycle the register is non-zero.
- R7: `rd_count` is 1 when the register is non-zero and 0 when it is zero, whether or not a read is requested.
- R8: `evt_out` is high exactly when `evt_en` is high and the register is non-zero.
- R9: When several writers deliver to one register in the same cycle, accumulate mode ORs all of their values, and overwrite mode takes the value of the lowest-numbered writer.
- R10: `host_peek` shows the register contents and reading it never changes them.
- R11: A `mode_set` pulse loads `mode_val` into the mode bit only while the register is zero. While the register is non-zero the pulse is ignored. A delivery in the same cycle as an accepted mode change uses the old mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | NUM_WRITERS | Per-writer delivery strobe |
| wr_sel | input | NUM_WRITERS*SEL_W | Per-writer target register index |
| wr_data | input | NUM_WRITERS*DATA_W | Per-writer delivered bit pattern |
| mode_set | input | NUM_REGS | Per-register mode change request |
| mode_val | input | NUM_REGS | Requested mode: 0 overwrite, 1 accumulate |
| evt_en | input | NUM_REGS | Per-register event enable |
| rd_req | input | NUM_REGS | Core blocking read request |
| rd_ack | output | NUM_REGS | Read completes this cycle |
| rd_data | output | NUM_REGS*DATA_W | Read value, valid with `rd_ack` |
| rd_count | output | NUM_REGS | Pending count (0 or 1) |
| host_peek | output | NUM_REGS*DATA_W | Non-destructive view of the contents |
| mode_now | output | NUM_REGS | Current mode bit |
| evt_out | output | NUM_REGS | Event: enabled and non-zero |

## Verification
The bench targets the cycle in which a read and a delivery coincide. A design that clears after merging would lose the new bits there, and one that skips the clear would return stale flags twice. It also sends three writers into one register in one cycle. A wrong priority shows up as the wrong survivor in overwrite mode, and a missing merge shows up as missing bits in accumulate mode. Reads requested while the register is empty must stall rather than acknowledge zero. Mode changes tried while the register is non-zero must leave `mode_now` unchanged; a design that accepted them would switch a half-accumulated register to overwrite.

// File: rtl/sig_notify_pkg.sv
package sig_notify_pkg;
   typedef enum logic {
      MODE_OVERWRITE = 1'b0,
      MODE_ACCUM     = 1'b1
   } sig_mode_e;
endpackage

// File: rtl/sig_write_merge.sv
// Collects every writer aimed at one register: OR of all, and lowest-index value.
module sig_write_merge #(
   parameter int DATA_W      = 32,
   parameter int NUM_WRITERS = 3,
   parameter int SEL_W       = 1,
   parameter int REG_IDX     = 0
) (
   input  logic [NUM_WRITERS-1:0]        wr_en,
   input  logic [NUM_WRITERS*SEL_W-1:0]  wr_sel,
   input  logic [NUM_WRITERS*DATA_W-1:0] wr_data,
   output logic                          hit,
   output logic [DATA_W-1:0]             or_val,
   output logic [DATA_W-1:0]             first_val
);
   logic [NUM_WRITERS-1:0] match;

   for (genvar w = 0; w < NUM_WRITERS; w++) begin : g_match
      assign match[w] = wr_en[w] && (wr_sel[w*SEL_W +: SEL_W] == SEL_W'(REG_IDX));
   end

   always_comb begin
      or_val    = '0;
      first_val = '0;
      for (int w = NUM_WRITERS - 1; w >= 0; w--) begin
         if (match[w]) begin
            or_val    = or_val | wr_data[w*DATA_W +: DATA_W];
            first_val = wr_data[w*DATA_W +: DATA_W];
         end
      end
   end

   assign hit = |match;

   // R9
   always_comb begin
      if (hit === 1'b1) begin
         first_in_or_chk: assert ((or_val & first_val) == first_val);
      end
   end
endmodule

// File: rtl/sig_slot.sv
// One notification register: mode bit, blocking read-and-clear, event.
module sig_slot
   import sig_notify_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hit,
   input  logic [DATA_W-1:0] or_val,
   input  logic [DATA_W-1:0] first_val,
   input  logic              rd_req,
   input  logic              mode_set,
   input  logic              mode_val,
   input  logic              evt_en,
   output logic              rd_ack,
   output logic [DATA_W-1:0] val,
   output logic              pending,
   output logic              mode_bit,
   output logic              evt
);
   logic [DATA_W-1:0] val_q, val_d, base;
   sig_mode_e         mode_q;

   always_comb begin
      rd_ack = rd_req && (val_q != '0);
      base   = rd_ack ? '0 : val_q;
      if (hit) begin
         val_d = (mode_q == MODE_ACCUM) ? (base | or_val) : first_val;
      end else begin
         val_d = base;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         val_q  <= '0;
         mode_q <= MODE_OVERWRITE;
      end else begin
         val_q <= val_d;
         if (mode_set && (val_q == '0)) begin
            mode_q <= sig_mode_e'(mode_val);
         end
      end
   end

   assign val      = val_q;
   assign pending  = (val_q != '0);
   assign mode_bit = mode_q;
   assign evt      = evt_en && pending;

   // R4
   clear_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_ack && !hit) |=> (val_q == '0));
   // R3
   no_bit_loss_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == MODE_ACCUM && !rd_ack) |=> ((val_q & $past(val_q)) == $past(val_q)));
   // R2
   overwrite_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == MODE_OVERWRITE && hit) |=> (val_q == $past(first_val)));
   // R11
   mode_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (val_q != '0) |=> $stable(mode_q));
endmodule

// File: rtl/sig_notify.sv
module sig_notify #(
   parameter int DATA_W      = 32,
   parameter int NUM_REGS    = 2,
   parameter int NUM_WRITERS = 3,
   localparam int SEL_W      = $clog2(NUM_REGS)
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [NUM_WRITERS-1:0]        wr_en,
   input  logic [NUM_WRITERS*SEL_W-1:0]  wr_sel,
   input  logic [NUM_WRITERS*DATA_W-1:0] wr_data,
   input  logic [NUM_REGS-1:0]           mode_set,
   input  logic [NUM_REGS-1:0]           mode_val,
   input  logic [NUM_REGS-1:0]           evt_en,
   input  logic [NUM_REGS-1:0]           rd_req,
   output logic [NUM_REGS-1:0]           rd_ack,
   output logic [NUM_REGS*DATA_W-1:0]    rd_data,
   output logic [NUM_REGS-1:0]           rd_count,
   output logic [NUM_REGS*DATA_W-1:0]    host_peek,
   output logic [NUM_REGS-1:0]           mode_now,
   output logic [NUM_REGS-1:0]           evt_out
);
   if (DATA_W < 1)      begin : g_bad_w   $error("DATA_W must be positive"); end
   if (NUM_REGS < 2)    begin : g_bad_r   $error("NUM_REGS must be at least 2"); end
   if (NUM_WRITERS < 1) begin : g_bad_n   $error("NUM_WRITERS must be positive"); end

   for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
      logic              hit;
      logic [DATA_W-1:0] or_val, first_val, val;

      sig_write_merge #(
         .DATA_W(DATA_W), .NUM_WRITERS(NUM_WRITERS), .SEL_W(SEL_W), .REG_IDX(r)
      ) u_merge (
         .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
         .hit(hit), .or_val(or_val), .first_val(first_val)
      );

      sig_slot #(.DATA_W(DATA_W)) u_slot (
         .clk(clk), .rst_n(rst_n), .hit(hit), .or_val(or_val), .first_val(first_val),
         .rd_req(rd_req[r]), .mode_set(mode_set[r]), .mode_val(mode_val[r]),
         .evt_en(evt_en[r]), .rd_ack(rd_ack[r]), .val(val), .pending(rd_count[r]),
         .mode_bit(mode_now[r]), .evt(evt_out[r])
      );

      assign rd_data[r*DATA_W +: DATA_W]   = val;
      assign host_peek[r*DATA_W +: DATA_W] = val;
   end
endmodule

// File: tb/sig_notify_bench.sv
module sig_notify_bench;
   localparam int DW = 32;
   localparam int NR = 2;
   localparam int NW = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [NW-1:0]    wr_en = '0;
   logic [NW-1:0]    wr_sel = '0;
   logic [NW*DW-1:0] wr_data = '0;
   logic [NR-1:0]    mode_set = '0, mode_val = '0, evt_en = '0, rd_req = '0;
   logic [NR-1:0]    rd_ack, rd_count, mode_now, evt_out;
   logic [NR*DW-1:0] rd_data, host_peek;

   always #4 clk = ~clk;

   sig_notify #(.DATA_W(DW), .NUM_REGS(NR), .NUM_WRITERS(NW)) u_sig_notify (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .mode_set(mode_set), .mode_val(mode_val), .evt_en(evt_en), .rd_req(rd_req),
      .rd_ack(rd_ack), .rd_data(rd_data), .rd_count(rd_count), .host_peek(host_peek),
      .mode_now(mode_now), .evt_out(evt_out)
   );

   int checks = 0;
   int errors = 0;
   string tag = "R1";
   logic [DW-1:0] m_val [NR];
   bit            m_mode [NR];
   bit            done = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [DW-1:0] act, input logic [DW-1:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic idle();
      wr_en = '0; mode_set = '0; rd_req = '0;
   endtask

   task automatic put(input int w, input int r, input logic [DW-1:0] d);
      wr_en[w] = 1'b1;
      wr_sel[w] = r[0];
      wr_data[w*DW +: DW] = d;
   endtask

   // compare, advance the model by one clock, return at the next falling edge
   task automatic step();
      logic [DW-1:0] nxt [NR];
      bit            nmode [NR];
      #1;
      for (int r = 0; r < NR; r++) begin
         bit ack;
         bit found;
         logic [DW-1:0] orv, first, base;
         ack = rd_req[r] && (m_val[r] != 0);
         chk(host_peek[r*DW +: DW] == m_val[r], tag, "contents", host_peek[r*DW +: DW], m_val[r]);
         chk(rd_ack[r] == ack, tag, "rd_ack (R6)", DW'(rd_ack[r]), DW'(ack));
         if (ack) chk(rd_data[r*DW +: DW] == m_val[r], tag, "rd_data (R4)", rd_data[r*DW +: DW], m_val[r]);
         chk(rd_count[r] == (m_val[r] != 0), tag, "count (R7)", DW'(rd_count[r]), DW'(m_val[r] != 0));
         chk(evt_out[r] == (evt_en[r] && m_val[r] != 0), tag, "event (R8)", DW'(evt_out[r]), DW'(evt_en[r] && m_val[r] != 0));
         chk(mode_now[r] == m_mode[r], tag, "mode (R11)", DW'(mode_now[r]), DW'(m_mode[r]));
         found = 0; orv = 0; first = 0;
         for (int w = 0; w < NW; w++) begin
            if (wr_en[w] && int'(wr_sel[w]) == r) begin
               if (!found) first = wr_data[w*DW +: DW];
               found = 1;
               orv |= wr_data[w*DW +: DW];
            end
         end
         base = ack ? '0 : m_val[r];
         nxt[r] = !found ? base : (m_mode[r] ? (base | orv) : first);
         nmode[r] = (mode_set[r] && m_val[r] == 0) ? mode_val[r] : m_mode[r];
      end
      @(posedge clk);
      for (int r = 0; r < NR; r++) begin
         m_val[r] = nxt[r];
         m_mode[r] = nmode[r];
      end
      @(negedge clk);
   endtask

   initial begin : watchdog
      repeat (5000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin : stim
      for (int r = 0; r < NR; r++) begin m_val[r] = '0; m_mode[r] = 0; end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state
      tag = "R1";
      step();
      // R2: overwrite replaces; R1: other register untouched
      tag = "R2";
      put(0, 0, 32'h0000_00A5); step(); idle();
      put(1, 0, 32'h0000_0F00); step(); idle();
      step();
      // R4: read returns value and clears
      tag = "R4";
      rd_req[0] = 1'b1; step(); idle(); step();
      // R6: read of empty register stalls, then completes
      tag = "R6";
      rd_req[0] = 1'b1; step(); step();
      put(2, 0, 32'h8000_0001); step();
      step(); idle(); step();
      // R11: switch register 1 to accumulate while empty
      tag = "R11";
      mode_set[1] = 1'b1; mode_val[1] = 1'b1; step(); idle();
      // R3: accumulate
      tag = "R3";
      put(0, 1, 32'h1); step(); idle();
      put(2, 1, 32'h4); step(); idle();
      // R11: ignored while non-zero
      tag = "R11";
      mode_set[1] = 1'b1; mode_val[1] = 1'b0; step(); idle(); step();
      // R9: three writers in one cycle, accumulate and overwrite
      tag = "R9";
      put(0, 1, 32'h10); put(1, 1, 32'h200); put(2, 1, 32'h3000); step(); idle();
      put(1, 0, 32'hCAFE); put(2, 0, 32'hBEEF); put(0, 1, 32'h0); step(); idle();
      put(0, 0, 32'h1111); put(1, 0, 32'h2222); put(2, 0, 32'h4444); step(); idle();
      // R8: event gating
      tag = "R8";
      evt_en = 2'b11; step(); evt_en = 2'b01; step();
      // R5: read and delivery in the same cycle
      tag = "R5";
      rd_req = 2'b11; put(0, 1, 32'h80); put(1, 0, 32'h5); step(); idle();
      step();
      rd_req = 2'b11; step(); idle(); step();
      // R10: repeated status views do not alter contents
      tag = "R10";
      put(2, 1, 32'h7); step(); idle(); step(); step();
      // R7: count with and without requests
      tag = "R7";
      rd_req[1] = 1'b1; step(); step(); idle();
      // R11: accepted change back to overwrite, delivery same cycle uses old mode
      tag = "R11";
      mode_set[1] = 1'b1; mode_val[1] = 1'b0; put(0, 1, 32'h3); step(); idle();
      put(1, 1, 32'h40); step(); idle(); step();
      // R1: reset clears everything
      tag = "R1";
      rst_n = 1'b0; step();
      for (int r = 0; r < NR; r++) begin m_val[r] = '0; m_mode[r] = 0; end
      rst_n = 1'b1; evt_en = '0; step();
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule